// File: doc/BRIEF.md
# Pin Interrupt Controller

This block turns up to 32 pin inputs into one interrupt line. The pins are picked from a wider set of source groups. Each group carries 32 pins. An assignment register chooses which group feeds each 8-pin byte lane. The chosen pins pass through a synchronizer and then through a per-pin polarity inversion. After that, each pin is watched either for its level or for a rising transition. Request bits collect the result. A mask decides which requests drive the combined interrupt output. A separate latch register records every rising transition, whether the pin is masked or not.

Software reaches the block over a simple word-wide register port. The port has a request strobe, a write enable, a byte offset and an access-size code. Mask, edge-mode and invert state are held in internal registers. Software cannot address these registers directly. Each one has a set alias and a clear alias, and both aliases read back the live value. The reset value of the assignment register depends on which instance of the block is built.

Top module: `pin_irq_ctrl`

## Requirements
- R1: Size code 2 means a 32-bit access. An access is rejected with `err_o` high in the same cycle in any of three cases: the size code is not 2, the offset is misaligned, or the offset is 0x28 or above. A rejected access changes no register state and returns 0 on `rdata_o`.
- R2: The set aliases are mask at 0x00, edge at 0x10 and invert at 0x18. Writing to one sets every internal bit that is written as 1. Bits written as 0 keep their value.
- R3: The clear aliases are mask at 0x04, edge at 0x14 and invert at 0x1C. Writing to one clears every internal bit that is written as 1. Bits written as 0 keep their value.
- R4: A read of either the set alias or the clear alias returns the current internal value.
- R5: The assignment register sits at 0x0C and can be read and written. Its reset value is 0x00000101 for instance indexes 0 and 2, 0x01010000 for index 1 and 0x02020303 for index 3.
- R6: Pin j belongs to lane k = j/8. It is taken from source group g = assign[8k+2:8k], which is input bit g*32+j of `pins_i`.
- R7: Pin-state sits at 0x20. It reads the synchronized pin value XOR invert. A write to it is accepted and has no effect.
- R8: The request register sits at 0x08. A pin with edge bit 1 sets its request bit on a 0-to-1 transition of its inverted value. The bit stays set until a 1 is written to it at 0x08. Writing 0 has no effect. If a new edge and a clear arrive in the same cycle, the edge wins.
- R9: A pin with edge bit 0 has a request bit that follows its inverted level. Writes to 0x08 do not change that bit.
- R10: The latch register sits at 0x24. It records every rising transition of the inverted value, for any mask or edge setting. Writing 1 to a bit clears it.
- R11: `irq_o` is high exactly when some pin has both its request bit and its mask bit set.
- R12: After reset, mask, edge, invert, request and latch all read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset of the access |
| size_i | input | 2 | Access size code (2 = 32-bit) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the access |
| err_o | output | 1 | Access rejected, same cycle |
| pins_i | input | NUM_GROUPS*32 | Pin inputs, bit g*32+j is group g pin j |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench first mixes set and clear writes whose 1 and 0 patterns overlap, and reads each result through both aliases. A design that treated either alias as a plain store would lose bits that should have been kept. It then sends size-code and offset errors and checks that state does not move, which catches a decoder that still commits rejected writes. It drives the same pin position in several groups and then remaps a lane, so a mux that ignores the assignment or indexes the wrong lane shows up as a pin-state mismatch. Finally, it checks that an edge-mode request survives the pin dropping and a write of 0, and clears only on a write of 1. It checks that a level-mode request ignores that same write, and that latch and interrupt track the mask correctly. These checks expose any confusion between sticky and level requests.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIN_W    = 32;
  localparam int LANE_W   = 8;
  localparam int NUM_LANE = PIN_W / LANE_W;
  localparam int NUM_REGS = 10;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [3:0] {
    RI_MASK_SET = 4'd0, RI_MASK_CLR = 4'd1, RI_REQ     = 4'd2, RI_ASSIGN  = 4'd3,
    RI_EDGE_SET = 4'd4, RI_EDGE_CLR = 4'd5, RI_INV_SET = 4'd6, RI_INV_CLR = 4'd7,
    RI_PSTATE   = 4'd8, RI_LATCH    = 4'd9
  } reg_idx_e;

  function automatic logic [PIN_W-1:0] assign_rst(input int idx);
    case (idx)
      1:       return 32'h0101_0000;
      3:       return 32'h0202_0303;
      default: return 32'h0000_0101;
    endcase
  endfunction
endpackage

// File: rtl/pic_setclr_reg.sv
module pic_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (set_en_i) q_o <= q_o | wdata_i;
    else if (clr_en_i) q_o <= q_o & ~wdata_i;
  end
endmodule

// File: rtl/pic_lane_mux.sv
module pic_lane_mux import pic_pkg::*; #(
  parameter int NUM_GROUPS = 8
) (
  input  logic [NUM_GROUPS*PIN_W-1:0] pins_i,
  input  logic [PIN_W-1:0]            assign_i,
  output logic [PIN_W-1:0]            sel_o
);
  localparam int GSEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  for (genvar k = 0; k < NUM_LANE; k++) begin : g_lane
    logic [GSEL_W-1:0] grp;
    assign grp = assign_i[k*LANE_W +: GSEL_W];
    always_comb begin
      for (int j = 0; j < LANE_W; j++) begin
        if (int'(grp) < NUM_GROUPS)
          sel_o[k*LANE_W+j] = pins_i[int'(grp)*PIN_W + k*LANE_W + j];
        else
          sel_o[k*LANE_W+j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_pin_sync.sv
module pic_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pic_detect.sv
module pic_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] edge_mode_i,
  input  logic [W-1:0] req_clr_i,
  input  logic [W-1:0] latch_clr_i,
  output logic [W-1:0] req_o,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  assign rise_o = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      req_o   <= '0;
      latch_o <= '0;
    end else begin
      prev_q  <= lvl_i;
      // a new edge wins over a same-cycle clear
      req_o   <= (edge_mode_i & ((req_o & ~req_clr_i) | rise_o)) | (~edge_mode_i & lvl_i);
      latch_o <= (latch_o & ~latch_clr_i) | rise_o;
    end
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl import pic_pkg::*; #(
  parameter int NUM_GROUPS  = 8,
  parameter int INST_IDX    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [5:0]                  addr_i,
  input  logic [1:0]                  size_i,
  input  logic [PIN_W-1:0]            wdata_i,
  output logic [PIN_W-1:0]            rdata_o,
  output logic                        err_o,
  input  logic [NUM_GROUPS*PIN_W-1:0] pins_i,
  output logic                        irq_o
);
  logic [3:0]          reg_idx;
  logic                off_ok, acc, wr;
  logic [NUM_REGS-1:0] wr_sel;
  logic [PIN_W-1:0]    mask_q, edge_q, inv_q, assign_q;
  logic [PIN_W-1:0]    pin_sel, pin_sync, pin_lvl;
  logic [PIN_W-1:0]    req_q, latch_q, rise;

  assign reg_idx = addr_i[5:2];
  assign off_ok  = (addr_i[1:0] == 2'b00) && (int'(reg_idx) < NUM_REGS);
  assign err_o   = req_i && ((size_i != SIZE_WORD) || !off_ok);
  assign acc     = req_i && !err_o;
  assign wr      = acc && we_i;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_wsel
    assign wr_sel[k] = wr && (int'(reg_idx) == k);
  end

  pic_setclr_reg #(.W(PIN_W)) u_mask (
    .clk_i, .rst_ni, .set_en_i(wr_sel[RI_MASK_SET]), .clr_en_i(wr_sel[RI_MASK_CLR]),
    .wdata_i, .q_o(mask_q));
  pic_setclr_reg #(.W(PIN_W)) u_edge (
    .clk_i, .rst_ni, .set_en_i(wr_sel[RI_EDGE_SET]), .clr_en_i(wr_sel[RI_EDGE_CLR]),
    .wdata_i, .q_o(edge_q));
  pic_setclr_reg #(.W(PIN_W)) u_inv (
    .clk_i, .rst_ni, .set_en_i(wr_sel[RI_INV_SET]), .clr_en_i(wr_sel[RI_INV_CLR]),
    .wdata_i, .q_o(inv_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                assign_q <= assign_rst(INST_IDX);
    else if (wr_sel[RI_ASSIGN]) assign_q <= wdata_i;
  end

  pic_lane_mux #(.NUM_GROUPS(NUM_GROUPS)) u_mux (
    .pins_i, .assign_i(assign_q), .sel_o(pin_sel));

  pic_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_sel), .q_o(pin_sync));

  assign pin_lvl = pin_sync ^ inv_q;

  pic_detect #(.W(PIN_W)) u_det (
    .clk_i, .rst_ni,
    .lvl_i      (pin_lvl),
    .edge_mode_i(edge_q),
    .req_clr_i  (wr_sel[RI_REQ]   ? wdata_i : '0),
    .latch_clr_i(wr_sel[RI_LATCH] ? wdata_i : '0),
    .req_o      (req_q),
    .latch_o    (latch_q),
    .rise_o     (rise));

  assign irq_o = |(req_q & mask_q);

  always_comb begin
    rdata_o = '0;
    if (acc) begin
      case (reg_idx)
        RI_MASK_SET, RI_MASK_CLR: rdata_o = mask_q;
        RI_EDGE_SET, RI_EDGE_CLR: rdata_o = edge_q;
        RI_INV_SET,  RI_INV_CLR:  rdata_o = inv_q;
        RI_REQ:                   rdata_o = req_q;
        RI_ASSIGN:                rdata_o = assign_q;
        RI_PSTATE:                rdata_o = pin_lvl;
        RI_LATCH:                 rdata_o = latch_q;
        default:                  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker import pic_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [5:0]       addr_i,
  input logic [PIN_W-1:0] wdata_i,
  input logic             err_o,
  input logic             irq_o,
  input logic [PIN_W-1:0] mask_q,
  input logic [PIN_W-1:0] edge_q,
  input logic [PIN_W-1:0] inv_q,
  input logic [PIN_W-1:0] assign_q,
  input logic [PIN_W-1:0] req_q,
  input logic [PIN_W-1:0] latch_q,
  input logic [PIN_W-1:0] rise
);
  logic good_wr;
  assign good_wr = req_i && we_i && !err_o;

  a_r2_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_wr && addr_i == 6'h00) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  a_r3_edge_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_wr && addr_i == 6'h14) |=> ((edge_q & $past(wdata_i)) == '0));

  a_r1_err_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> ($stable(mask_q) && $stable(edge_q) && $stable(inv_q) && $stable(assign_q)));

  a_r10_latch_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((latch_q & $past(rise)) == $past(rise)));

  a_r11_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((req_q & mask_q) != '0));
endmodule

bind pin_irq_ctrl pic_checker u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .err_o, .irq_o,
  .mask_q, .edge_q, .inv_q, .assign_q, .req_q, .latch_q, .rise);

// File: tb/pin_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_irq_ctrl_tb_top;
  localparam int NG = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [5:0]    addr = '0;
  logic [1:0]    size = 2'd2;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, rdata3;
  logic          err, err3, irq, irq3;
  logic [NG*32-1:0] pins = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_irq_ctrl #(.NUM_GROUPS(NG), .INST_IDX(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .pins_i(pins), .irq_o(irq));

  pin_irq_ctrl #(.NUM_GROUPS(NG), .INST_IDX(3)) dut3_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .rdata_o(rdata3), .err_o(err3), .pins_i(pins), .irq_o(irq3));

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [5:0] a, input logic [1:0] sz,
                     input logic [31:0] d, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    #1;
    rd = rdata; er = err;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0; size = 2'd2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    bus(1'b1, a, 2'd2, d, rd, er);
  endtask

  task automatic rd_chk(input string r, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    bus(1'b0, a, 2'd2, 32'h0, rd, er);
    check(r, rd, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    check("R12 irq", {31'b0, irq}, 32'h0);
    rd_chk("R12 mask",  6'h00, 32'h0);
    rd_chk("R12 edge",  6'h14, 32'h0);
    rd_chk("R12 inv",   6'h18, 32'h0);
    rd_chk("R12 req",   6'h08, 32'h0);
    rd_chk("R12 latch", 6'h24, 32'h0);
    rd_chk("R5 assign inst0", 6'h0C, 32'h0000_0101);
    begin
      logic [31:0] rd; logic er;
      bus(1'b0, 6'h0C, 2'd2, 32'h0, rd, er);
      check("R5 assign inst3", rdata3, 32'h0202_0303);
    end
  endtask

  task automatic t_setclr;
    wr(6'h00, 32'hF0F0_00FF);
    rd_chk("R4 mask via clr alias", 6'h04, 32'hF0F0_00FF);
    wr(6'h00, 32'h0000_0F00);
    rd_chk("R2 mask set keeps zeros", 6'h00, 32'hF0F0_0FFF);
    wr(6'h04, 32'h0000_00F0);
    rd_chk("R3 mask clr", 6'h00, 32'hF0F0_0F0F);
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h10, 32'h0000_00A0);
    wr(6'h14, 32'h0000_0080);
    rd_chk("R3 edge clr", 6'h10, 32'h0000_0020);
    wr(6'h14, 32'hFFFF_FFFF);
    rd_chk("R3 edge all clear", 6'h14, 32'h0);
  endtask

  task automatic t_errors;
    logic [31:0] rd; logic er;
    bus(1'b1, 6'h28, 2'd2, 32'hFFFF_FFFF, rd, er);
    check("R1 undefined offset err", {31'b0, er}, 32'h1);
    bus(1'b1, 6'h00, 2'd1, 32'hFFFF_FFFF, rd, er);
    check("R1 half size err", {31'b0, er}, 32'h1);
    bus(1'b1, 6'h0E, 2'd2, 32'h0, rd, er);
    check("R1 misaligned err", {31'b0, er}, 32'h1);
    bus(1'b0, 6'h00, 2'd0, 32'h0, rd, er);
    check("R1 rejected read data", rd, 32'h0);
    rd_chk("R1 mask unchanged", 6'h00, 32'h0);
    rd_chk("R1 assign unchanged", 6'h0C, 32'h0000_0101);
    bus(1'b1, 6'h20, 2'd2, 32'hFFFF_FFFF, rd, er);
    check("R7 pin-state write accepted", {31'b0, er}, 32'h0);
    rd_chk("R7 pin-state write ignored", 6'h20, 32'h0);
  endtask

  task automatic t_lane;
    pins[0]  = 1'b1;
    pins[32] = 1'b0;
    wait_cyc(4);
    rd_chk("R6 group0 bit0 not selected", 6'h20, 32'h0);
    pins[0] = 1'b0; pins[32] = 1'b1; pins[16] = 1'b1; pins[48] = 1'b0;
    wait_cyc(4);
    rd_chk("R6 default lanes", 6'h20, 32'h0001_0001);
    wr(6'h0C, 32'h0700_0000);
    pins[7*32+24] = 1'b1;
    wait_cyc(4);
    rd_chk("R6 remapped lanes", 6'h20, 32'h0101_0000);
    pins = '0;
    wr(6'h0C, 32'h0000_0101);
    wait_cyc(4);
    wr(6'h24, 32'hFFFF_FFFF);
    rd_chk("R10 latch cleared", 6'h24, 32'h0);
  endtask

  task automatic t_level;
    wr(6'h00, 32'h0000_0004);
    pins[34] = 1'b1;
    wait_cyc(4);
    rd_chk("R9 level request", 6'h08, 32'h0000_0004);
    check("R11 irq level", {31'b0, irq}, 32'h1);
    wr(6'h08, 32'h0000_0004);
    wait_cyc(1);
    rd_chk("R9 write ignored on level pin", 6'h08, 32'h0000_0004);
    pins[34] = 1'b0;
    wait_cyc(4);
    rd_chk("R9 level follows low", 6'h08, 32'h0);
    check("R11 irq drops", {31'b0, irq}, 32'h0);
    rd_chk("R10 latch from level pin", 6'h24, 32'h0000_0004);
    wr(6'h24, 32'h0000_0004);
    rd_chk("R10 latch w1c", 6'h24, 32'h0);
  endtask

  task automatic t_edge;
    wr(6'h10, 32'h0000_0008);
    pins[35] = 1'b1;
    wait_cyc(4);
    rd_chk("R8 edge sets request", 6'h08, 32'h0000_0008);
    check("R11 irq masked off", {31'b0, irq}, 32'h0);
    rd_chk("R10 latch ignores mask", 6'h24, 32'h0000_0008);
    wr(6'h00, 32'h0000_0008);
    wait_cyc(1);
    check("R11 irq after unmask", {31'b0, irq}, 32'h1);
    pins[35] = 1'b0;
    wait_cyc(4);
    wr(6'h08, 32'h0000_0000);
    wait_cyc(1);
    rd_chk("R8 sticky after pin low and zero write", 6'h08, 32'h0000_0008);
    wr(6'h08, 32'h0000_0008);
    wait_cyc(1);
    rd_chk("R8 w1c clears", 6'h08, 32'h0);
    check("R11 irq cleared", {31'b0, irq}, 32'h0);
    wr(6'h24, 32'hFFFF_FFFF);
  endtask

  task automatic t_invert;
    wr(6'h18, 32'h0001_0000);
    wait_cyc(2);
    rd_chk("R7 inverted pin-state", 6'h20, 32'h0001_0000);
    rd_chk("R10 invert toggle latched", 6'h24, 32'h0001_0000);
    wr(6'h10, 32'h0001_0000);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    pins[16] = 1'b1;
    wait_cyc(4);
    rd_chk("R8 falling inverted no request", 6'h08, 32'h0);
    pins[16] = 1'b0;
    wait_cyc(4);
    rd_chk("R8 inverted rise sets request", 6'h08, 32'h0001_0000);
    rd_chk("R2 invert live", 6'h1C, 32'h0001_0000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_setclr();
    t_errors();
    t_lane();
    t_level();
    t_edge();
    t_invert();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule